// File: doc/BRIEF.md
# I2C Waveform Sequencer

This block is an I2C master that contains no knowledge of bytes or bus phases. Instead, the host writes a small program into an instruction memory of `DEPTH` entries. Each entry states three things: the level the clock line should have, the level the data line should have, and the address of the entry that follows. A start pulse runs the program from entry 0. The block then walks the chain of next-address links until it reaches an entry whose continue flag is clear.

Each running entry drives both pins for a fixed time, set by the `step_len` input. An entry can also carry a sample flag. At the end of such an entry the block shifts the sampled data line into a read-data register, so a read transfer leaves its last bytes in the low bits. The host writes every bus phase as separate entries:

- **Start condition:** three entries.
- **Written bit:** three entries (clock low, high, low, with data held).
- **Read bit:** four entries (data released, sampled while the clock is high).
- **Acknowledge slot:** a written 1.
- **Stop condition:** three entries.

Both lines are open-drain. The block outputs only a pull-low enable for each line.

The controller has four states:

| State | Action |
|-------|--------|
| IDLE | Waits for `start`. |
| LOAD | Reads the current entry from memory. |
| EXEC | Applies the pin levels and examines the continue flag. |
| HOLD | Counts out the step time. |

It has five transitions:

| Transition | Taken when |
|------------|------------|
| IDLE→LOAD | `start` is seen. |
| LOAD→EXEC | Always, after one cycle. |
| EXEC→HOLD | The entry continues. |
| EXEC→IDLE | The entry halts. |
| HOLD→LOAD | The step counter is exhausted. |

Top module: `i2cseq_top`

## Requirements
- R1: After reset, `busy` is 0, `scl_pull` and `sda_pull` are 0 (both lines released), and `rd_data` is 0.
- R2: A cycle with `wr_en` high stores an entry at the address in `wr_word[27:18]`. The stored fields are: continue in bit 13, sample in bit 12, clock-low request in bit 11, data-low request in bit 10, and next address in bits 9:0. All other bits of `wr_word` are ignored.
- R3: A `start` pulse while idle raises `busy` on the following cycle and executes entry 0 first. `busy` stays high until a halting entry has been executed.
- R4: When an entry is executed, `scl_pull` takes that entry's bit 11 and `sda_pull` takes its bit 10, where 1 pulls the line low.
- R5: A continuing entry keeps its pin levels for `max(step_len,1)+2` cycles before the next entry's levels appear. A value of 0 in `step_len` therefore behaves as 1.
- R6: After a continuing entry, the next entry executed is the one its next-address field names, not the following memory address.
- R7: An entry with bit 13 clear ends the run. Its pin levels are applied on the same edge at which `busy` falls, and they are held for as long as the block stays idle.
- R8: At the last cycle of a continuing entry with bit 12 set, `rd_data` shifts left by one and takes the `sda_in` level into bit 0. No other entry, and no idle cycle without start, changes `rd_data`.
- R9: `rd_data` is 0 in the first cycle that `busy` is high.
- R10: A `start` pulse while `busy` is high has no effect on the run in progress.
- R11: When more than 32 bits are sampled in one run, `rd_data` holds the most recent 32, with the newest in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Instruction write strobe |
| wr_word | input | 32 | Instruction word, carrying its own address |
| start | input | 1 | Run the program from entry 0 |
| step_len | input | CNT_W (16) | Hold time per entry, in cycles |
| sda_in | input | 1 | Sensed level of the data line |
| busy | output | 1 | High while a program runs |
| rd_data | output | RD_W (32) | Sampled bits, newest in bit 0 |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |

## Verification
The bench builds the block with its default parameters: 1024 entries, a 32-bit read register and a 16-bit step counter. With the full memory, programs can be laid out with strides of 1, 2, 3 and 5 entries, reaching addresses near 416. Sequential halting entries are planted at addresses 1 and 2, so that a design that ignored the next-address links would stop early. Runtime `step_len` values of 0 through 3 exercise the step timing. One read program samples 40 bits, which overruns the 32-bit register and exposes the order in which older bits are discarded.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    // Field positions inside a host instruction word
    localparam int SELF_LSB = 18;
    localparam int BIT_CONT = 13;
    localparam int BIT_SMP  = 12;
    localparam int BIT_SCL  = 11;
    localparam int BIT_SDA  = 10;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_EXEC,
        SQ_HOLD
    } sq_state_e;

    typedef struct packed {
        logic cont;
        logic smp;
        logic scl_lo;
        logic sda_lo;
    } sq_flags_t;

endpackage

// File: rtl/i2cseq_store.sv
module i2cseq_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int EW    = AW + 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [EW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [EW-1:0] rd_q
);

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            // a zero length is treated as one cycle
            cnt <= (len == '0) ? '0 : len - CNT_W'(1);
        end else if (run && !done) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/i2cseq_shift.sv
module i2cseq_shift #(
    parameter int RD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic            bit_in,
    output logic [RD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= {q[RD_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  sq_flags_t     ent_flags,
    input  logic [AW-1:0] ent_next,
    input  logic          hold_done,
    output logic [AW-1:0] pc,
    output logic          fetch_en,
    output logic          hold_load,
    output logic          hold_run,
    output logic          shift_en,
    output logic          shift_clr,
    output logic          busy,
    output logic          scl_pull,
    output logic          sda_pull
);

    sq_state_e state, state_nx;
    logic      cur_smp;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE: if (start) state_nx = SQ_LOAD;
            SQ_LOAD: state_nx = SQ_EXEC;
            SQ_EXEC: state_nx = ent_flags.cont ? SQ_HOLD : SQ_IDLE;
            SQ_HOLD: if (hold_done) state_nx = SQ_LOAD;
        endcase
    end

    // registered outputs and program counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
            cur_smp  <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: if (start) pc <= '0;
                SQ_LOAD: ;
                SQ_EXEC: begin
                    scl_pull <= ent_flags.scl_lo;
                    sda_pull <= ent_flags.sda_lo;
                    cur_smp  <= ent_flags.cont & ent_flags.smp;
                    pc       <= ent_next;
                end
                SQ_HOLD: ;
            endcase
        end
    end

    // decoded strobes
    always_comb begin
        busy      = (state != SQ_IDLE);
        fetch_en  = (state == SQ_LOAD);
        hold_load = (state == SQ_EXEC);
        hold_run  = (state == SQ_HOLD);
        shift_en  = (state == SQ_HOLD) && hold_done && cur_smp;
        shift_clr = (state == SQ_IDLE) && start;
    end

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int RD_W  = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_word,
    input  logic             start,
    input  logic [CNT_W-1:0] step_len,
    input  logic             sda_in,
    output logic             busy,
    output logic [RD_W-1:0]  rd_data,
    output logic             scl_pull,
    output logic             sda_pull
);

    localparam int AW = $clog2(DEPTH);
    localparam int EW = AW + 4;

    logic [AW-1:0] wr_addr;
    logic [EW-1:0] wr_data;
    logic [EW-1:0] ent_q;
    logic [AW-1:0] pc;
    logic          fetch_en, hold_load, hold_run, hold_done;
    logic          shift_en, shift_clr;
    sq_flags_t     ent_flags;
    logic          unused_word;

    assign unused_word = ^wr_word;
    assign wr_addr = wr_word[SELF_LSB +: AW];
    assign wr_data = {wr_word[BIT_CONT], wr_word[BIT_SMP],
                      wr_word[BIT_SCL], wr_word[BIT_SDA], wr_word[AW-1:0]};
    assign ent_flags = sq_flags_t'(ent_q[EW-1:AW]);

    i2cseq_store #(.DEPTH(DEPTH), .AW(AW), .EW(EW)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (fetch_en),
        .rd_addr (pc),
        .rd_q    (ent_q)
    );

    i2cseq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hold_load),
        .run   (hold_run),
        .len   (step_len),
        .done  (hold_done)
    );

    i2cseq_shift #(.RD_W(RD_W)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (shift_clr),
        .en     (shift_en),
        .bit_in (sda_in),
        .q      (rd_data)
    );

    i2cseq_ctrl #(.AW(AW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ent_flags (ent_flags),
        .ent_next  (ent_q[AW-1:0]),
        .hold_done (hold_done),
        .pc        (pc),
        .fetch_en  (fetch_en),
        .hold_load (hold_load),
        .hold_run  (hold_run),
        .shift_en  (shift_en),
        .shift_clr (shift_clr),
        .busy      (busy),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
    parameter int RD_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            scl_pull,
    input logic            sda_pull,
    input logic [RD_W-1:0] rd_data,
    input logic            hold_run,
    input logic            hold_done
);

    assert_step_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_run && !hold_done) |=> ($stable(scl_pull) && $stable(sda_pull)));

    assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(scl_pull) && $stable(sda_pull)));

    assert_clear_on_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rd_data == '0));

    assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rd_data));

endmodule

bind i2cseq_top i2cseq_chk #(.RD_W(RD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .rd_data   (rd_data),
    .hold_run  (hold_run),
    .hold_done (hold_done)
);

// File: tb/i2cseq_tb.sv
module i2cseq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        start = 1'b0;
    logic [15:0] step_len = 16'd1;
    logic        sda_in = 1'b1;
    logic        busy;
    logic [31:0] rd_data;
    logic        scl_pull, sda_pull;

    int n_chk = 0;
    int n_err = 0;
    int sda_mode = 1;   // 0 low, 1 high, 2 toggle each cycle
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    i2cseq_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .start    (start),
        .step_len (step_len),
        .sda_in   (sda_in),
        .busy     (busy),
        .rd_data  (rd_data),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // data line stimulus
    always @(negedge clk) begin
        case (sda_mode)
            0:       sda_in <= 1'b0;
            1:       sda_in <= 1'b1;
            default: sda_in <= ~sda_in;
        endcase
    end

    // behavioural reference model
    logic [13:0] bm [0:1023];
    bit          m_busy, m_scl, m_sda, m_smp;
    logic [31:0] m_rd;
    int          m_t, m_pc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_scl = 0; m_sda = 0; m_smp = 0;
            m_rd = '0; m_t = 0; m_pc = 0;
        end else begin
            if (m_busy) begin
                m_t--;
                if (m_t == 2 && m_smp) m_rd = {m_rd[30:0], sda_in};
                if (m_t == 0) begin
                    logic [13:0] e;
                    e = bm[m_pc];
                    m_scl = e[11];
                    m_sda = e[10];
                    if (!e[13]) m_busy = 0;
                    else begin
                        m_t   = ((step_len == 0) ? 1 : int'(step_len)) + 2;
                        m_smp = e[12];
                    end
                    m_pc = int'(e[9:0]);
                end
            end else if (start) begin
                m_busy = 1; m_rd = '0; m_pc = 0; m_smp = 0; m_t = 2;
            end
            if (wr_en) bm[wr_word[27:18]] = wr_word[13:0];
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R3 busy", {31'b0, busy}, {31'b0, m_busy});
            chk("R4 pins", {30'b0, scl_pull, sda_pull}, {30'b0, m_scl, m_sda});
            chk("R8 rd_data", rd_data, m_rd);
        end
    end

    // program construction
    int wp, stride, ncont;

    task automatic put(input logic [31:0] w);
        wr_en = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: junk in bits 31:28 and 17:14 must be ignored
    function automatic logic [31:0] mkword(int a, bit c, bit s, bit scl, bit sda, int n);
        return {4'hA, 10'(a), 4'h5, c, s, ~scl, ~sda, 10'(n)};
    endfunction

    task automatic prog_begin(input int s);
        wp = 0; stride = s; ncont = 0;
    endtask

    task automatic emit(input bit s, input bit scl, input bit sda);
        int n;
        n = (wp + stride) % 1024;
        put(mkword(wp, 1'b1, s, scl, sda, n));
        wp = n;
        ncont++;
    endtask

    task automatic halt(input bit scl, input bit sda);
        put(mkword(wp, 1'b0, 1'b0, scl, sda, wp));
    endtask

    task automatic wbit(input bit b);
        emit(0, 0, b); emit(0, 1, b); emit(0, 0, b);
    endtask

    task automatic rbit();
        emit(0, 0, 1); emit(0, 1, 1); emit(1, 1, 1); emit(0, 0, 1);
    endtask

    task automatic wbyte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        wbit(1'b1);
    endtask

    task automatic rbyte(input bit last);
        for (int i = 0; i < 8; i++) rbit();
        wbit(last);
    endtask

    task automatic startc();
        emit(0, 1, 1); emit(0, 1, 0); emit(0, 0, 0);
    endtask

    task automatic stopc();
        emit(0, 0, 0); emit(0, 1, 0); emit(0, 1, 1);
    endtask

    // run the stored program; poke>=0 pulses start again at that busy cycle
    task automatic run(input int poke, output int cyc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 clear at start", rd_data, 32'h0);
        cyc = 0;
        while (busy) begin
            cyc++;
            start = (cyc == poke);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int cyc;
        int exp_cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 pins", {30'b0, scl_pull, sda_pull}, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        cmp_on = 1'b1;

        // T1: write transfer, stride 3, sequential decoys at 1 and 2 (R6)
        put(mkword(1, 0, 0, 0, 0, 1));
        put(mkword(2, 0, 0, 0, 0, 2));
        step_len = 16'd3;
        prog_begin(3);
        startc(); wbyte(8'hA4); wbyte(8'h3C); stopc(); halt(1, 1);
        run(-1, cyc);
        exp_cyc = 2 + ncont * 5;
        chk("R6 R5 linked run length", cyc, exp_cyc);
        chk("R7 final pins released", {30'b0, scl_pull, sda_pull}, 32'h0);
        chk("R8 no samples", rd_data, 32'h0);

        // T2: read two bytes with the line high, stride 1
        step_len = 16'd1;
        sda_mode = 1;
        prog_begin(1);
        startc(); wbyte(8'h53); rbyte(0); rbyte(1); stopc(); halt(1, 1);
        run(-1, cyc);
        chk("R8 two read bytes", rd_data, 32'h0000FFFF);
        chk("R5 run length L=1", cyc, 2 + ncont * 3);

        // T3: rerun with the line low and a start pulse mid-run (R10)
        sda_mode = 0;
        exp_cyc = 2 + ncont * 3;
        run(10, cyc);
        chk("R10 start while busy ignored", cyc, exp_cyc);
        chk("R9 R8 rerun result", rd_data, 32'h0);

        // T4: five read bytes, toggling line, stride 2 (R11)
        step_len = 16'd2;
        sda_mode = 2;
        prog_begin(2);
        startc(); wbyte(8'h53);
        for (int k = 0; k < 5; k++) rbyte(k == 4);
        stopc(); halt(1, 1);
        run(-1, cyc);
        chk("R5 run length L=2", cyc, 2 + ncont * 4);
        sda_mode = 1;
        run(-1, cyc);
        chk("R11 forty samples keep last 32", rd_data, 32'hFFFFFFFF);

        // T5: zero step length, halt holding both lines low
        step_len = 16'd0;
        prog_begin(5);
        emit(0, 1, 1); emit(0, 0, 1); emit(1, 0, 0); halt(0, 0);
        run(-1, cyc);
        chk("R5 zero step length", cyc, 11);
        repeat (5) @(negedge clk);
        chk("R7 halt levels held", {30'b0, scl_pull, sda_pull}, 32'h3);
        chk("R7 idle", {31'b0, busy}, 32'h0);

        // T6: entry 0 halts immediately, clock high and data low
        put(mkword(0, 0, 0, 1, 0, 0));
        run(-1, cyc);
        chk("R3 R7 immediate halt", cyc, 2);
        chk("R4 halt pins", {30'b0, scl_pull, sda_pull}, 32'h1);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule